// File: doc/BRIEF.md
# Peripheral Control Register Bank

This block is a bank of fifteen 32-bit registers on a simple single-cycle processor data bus. It decodes its own address window and gives software access to the board's controls. It holds a scratch word for debugging and four LED enables. It also holds two three-colour LED selectors, two LED dimming duty values and four motor drive duty values. Software can read the live levels of four push buttons and four DIP switches.

Three registers carry a hardware-owned flag in bit 31. The transmit slot passes a byte to a serial transmitter over a valid/ready pair. `tx_valid` rises after software starts a transfer, and it stays high with `tx_byte` unchanged until `tx_ready` is sampled high. The flag is then gone in the next cycle. The receive slot takes bytes from a serial receiver over a valid/ready pair. `rx_ready` is low while an unread byte is held, so the receiver must keep `rx_valid` and its byte until `rx_ready` rises. The distance slot has no back-pressure: each `dist_valid` pulse overwrites the held value. Reading a receive or distance register clears its flag on the clock edge that ends the read.

A bus access lasts one cycle: `bus_sel` is high for that cycle, and read data is valid combinationally in the same cycle. Register k sits at byte address `BASE_ADDR + 4*k`, and the window spans `2**WIN_BITS` bytes.

Top module: `periph_regbank`

## Requirements
- R1: After synchronous reset, all stored registers, the transmit flag, the receive flag and the distance flag are zero. All LED, duty and `tx_valid` outputs are low, and `rx_ready` is high.
- R2: The read/write registers take a write only in the byte lanes whose `bus_be` bit is set. Lane j covers bits [8j+7:8j]. The other lanes keep their value. These registers are index 0 (debug, drives nothing), 3, 4, 5, 6, 7 and 10 to 13.
- R3: `led` follows bits [3:0] of index 3. `rgb0` and `rgb1` follow bits [2:0] of indices 4 and 6, with bit 0 for red, bit 1 for green and bit 2 for blue. The outputs change in the cycle after the write.
- R4: The low `DUTY_W` bits of indices 5 and 7 drive `rgb0_duty` and `rgb1_duty`. Indices 10, 11, 12 and 13 drive, in that order, `mot_left_bwd`, `mot_left_fwd`, `mot_right_bwd` and `mot_right_fwd`.
- R5: Index 8 reads `{28'b0, buttons}` and index 9 reads `{28'b0, switches}`. Writes to indices 2, 8, 9 and 14 change nothing.
- R6: The bank does not respond to an access outside the window, to an unaligned address, or to a word index from 15 up. Such a read returns zero and such a write changes nothing.
- R7: Index 1 reads `{busy, 23'b0, byte}`. A write with lane 0 enabled updates the byte. A write with lane 3 enabled and bit 31 set, made while idle, sets busy. `tx_valid` equals busy and `tx_byte` equals the byte.
- R8: While busy, `tx_byte` holds and writes to index 1 are ignored. A cycle with `tx_valid` and `tx_ready` both high clears busy at that edge.
- R9: Index 2 reads `{full, 23'b0, byte}`. When not full, `rx_ready` is high and a byte with `rx_valid` is stored and sets full. When full and no read of index 2 is under way, `rx_ready` is low and the offered byte is not taken. A read returns the flag set and clears it; the byte stays readable.
- R10: During a read of index 2, `rx_ready` is high even when full. A byte taken in that same cycle leaves the flag set with the new byte, while the read itself returns the old contents.
- R11: Index 14 reads `{full, value[30:0]}`. A `dist_valid` pulse stores `dist_value` and sets full, replacing any earlier value. A read clears full, unless a pulse arrives in the same cycle; in that case full stays set with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_be | input | 4 | Write byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_byte | output | 8 | Byte to transmit |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_ready | output | 1 | Bank can take a received byte |
| rx_byte | input | 8 | Received byte |
| dist_valid | input | 1 | New distance result pulse |
| dist_value | input | 31 | Distance result |
| buttons | input | 4 | Push button levels |
| switches | input | 4 | DIP switch levels |
| led | output | 4 | LED enables |
| rgb0 | output | 3 | First colour LED (red, green, blue) |
| rgb1 | output | 3 | Second colour LED (red, green, blue) |
| rgb0_duty | output | DUTY_W | First colour LED duty value |
| rgb1_duty | output | DUTY_W | Second colour LED duty value |
| mot_left_bwd | output | DUTY_W | Left motor reverse duty |
| mot_left_fwd | output | DUTY_W | Left motor forward duty |
| mot_right_bwd | output | DUTY_W | Right motor reverse duty |
| mot_right_fwd | output | DUTY_W | Right motor forward duty |

## Verification
Two events can meet in one cycle. A processor read can clear a receive or distance flag in the same cycle that the receiver or the distance unit delivers a new result. The bench provokes this by raising `rx_valid` or `dist_valid` in the very cycle the read strobe is active. It judges the result in two steps: the read must return the older contents with the flag set, and a second read must show the flag still set with the newly delivered value. A third read must then show the flag cleared.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;
  localparam int NUM_REGS = 15;
  localparam int IDX_W    = 4;
  localparam int SLOTS    = 2 ** IDX_W;

  localparam logic [IDX_W-1:0] IDX_DEBUG = 4'd0;
  localparam logic [IDX_W-1:0] IDX_TX    = 4'd1;
  localparam logic [IDX_W-1:0] IDX_RX    = 4'd2;
  localparam logic [IDX_W-1:0] IDX_LED   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_RGB0  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_DUTY0 = 4'd5;
  localparam logic [IDX_W-1:0] IDX_RGB1  = 4'd6;
  localparam logic [IDX_W-1:0] IDX_DUTY1 = 4'd7;
  localparam logic [IDX_W-1:0] IDX_BTN   = 4'd8;
  localparam logic [IDX_W-1:0] IDX_SW    = 4'd9;
  localparam logic [IDX_W-1:0] IDX_LBWD  = 4'd10;
  localparam logic [IDX_W-1:0] IDX_LFWD  = 4'd11;
  localparam logic [IDX_W-1:0] IDX_RBWD  = 4'd12;
  localparam logic [IDX_W-1:0] IDX_RFWD  = 4'd13;
  localparam logic [IDX_W-1:0] IDX_DIST  = 4'd14;

  typedef struct packed {
    logic             rd;
    logic             wr;
    logic [IDX_W-1:0] idx;
  } bus_req_t;

  // Plain storage slots: written by software, read back unchanged.
  function automatic logic is_rw(input int i);
    return (i == 0) || (i >= 3 && i <= 7) || (i >= 10 && i <= 13);
  endfunction
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
  parameter int          WIN_BITS  = 12
) (
  input  logic        sel,
  input  logic        we,
  input  logic [31:0] addr,
  output bus_req_t    req
);
  localparam int WORD_W = WIN_BITS - 2;
  localparam logic [WORD_W-1:0] WORD_LIMIT = WORD_W'(NUM_REGS);

  logic [WORD_W-1:0] word;
  logic in_win, aligned, in_range, hit;

  assign word     = addr[WIN_BITS-1:2];
  assign in_win   = (addr[31:WIN_BITS] == BASE_ADDR[31:WIN_BITS]);
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = (word < WORD_LIMIT);
  assign hit      = sel & in_win & aligned & in_range;

  assign req.rd  = hit & ~we;
  assign req.wr  = hit & we;
  assign req.idx = word[IDX_W-1:0];
endmodule

// File: rtl/regbank_rwreg.sv
module regbank_rwreg
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        q[8*b +: 8] <= '0;
      else if (we && be[b])
        q[8*b +: 8] <= wdata[8*b +: 8];
    end
  end
endmodule

// File: rtl/regbank_txslot.sv
module regbank_txslot (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       be_low,
  input  logic       be_top,
  input  logic [7:0] wbyte,
  input  logic       wstart,
  input  logic       ready,
  output logic       busy,
  output logic [7:0] byte_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      byte_q <= '0;
    end else if (busy) begin
      // offered byte is frozen until the transmitter takes it
      if (ready) busy <= 1'b0;
    end else if (wr) begin
      if (be_low) byte_q <= wbyte;
      if (be_top && wstart) busy <= 1'b1;
    end
  end
endmodule

// File: rtl/regbank_capture.sv
module regbank_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         clr,
  output logic         full,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      q    <= '0;
    end else begin
      // a new result outranks the read-clear of the same cycle
      if (load)     full <= 1'b1;
      else if (clr) full <= 1'b0;
      if (load) q <= din;
    end
  end
endmodule

// File: rtl/periph_regbank.sv
module periph_regbank
  import regbank_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
  parameter int          WIN_BITS  = 12,
  parameter int          DUTY_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [31:0]       bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_byte,
  input  logic              dist_valid,
  input  logic [30:0]       dist_value,
  input  logic [3:0]        buttons,
  input  logic [3:0]        switches,
  output logic [3:0]        led,
  output logic [2:0]        rgb0,
  output logic [2:0]        rgb1,
  output logic [DUTY_W-1:0] rgb0_duty,
  output logic [DUTY_W-1:0] rgb1_duty,
  output logic [DUTY_W-1:0] mot_left_bwd,
  output logic [DUTY_W-1:0] mot_left_fwd,
  output logic [DUTY_W-1:0] mot_right_bwd,
  output logic [DUTY_W-1:0] mot_right_fwd
);
  bus_req_t          req;
  logic [DATA_W-1:0] rw_q [SLOTS];
  logic              tx_busy;
  logic [7:0]        tx_byte_q;
  logic              rx_full;
  logic [7:0]        rx_data;
  logic              dist_full;
  logic [30:0]       dist_data;
  logic              rd_rx, rd_dist;
  logic [DATA_W-1:0] rdata_mux;

  regbank_decode #(.BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr), .req(req)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (is_rw(i)) begin : g_rw
      logic slot_we;
      assign slot_we = req.wr && (req.idx == IDX_W'(i));
      regbank_rwreg u_reg (
        .clk(clk), .rst(rst), .we(slot_we), .be(bus_be),
        .wdata(bus_wdata), .q(rw_q[i])
      );
    end else begin : g_none
      assign rw_q[i] = '0;
    end
  end

  regbank_txslot u_tx (
    .clk(clk), .rst(rst),
    .wr(req.wr && req.idx == IDX_TX),
    .be_low(bus_be[0]), .be_top(bus_be[3]),
    .wbyte(bus_wdata[7:0]), .wstart(bus_wdata[31]),
    .ready(tx_ready), .busy(tx_busy), .byte_q(tx_byte_q)
  );

  assign rd_rx    = req.rd && (req.idx == IDX_RX);
  assign rd_dist  = req.rd && (req.idx == IDX_DIST);
  assign rx_ready = ~rx_full | rd_rx;

  regbank_capture #(.W(8)) u_rx (
    .clk(clk), .rst(rst), .load(rx_valid && rx_ready), .din(rx_byte),
    .clr(rd_rx), .full(rx_full), .q(rx_data)
  );

  regbank_capture #(.W(31)) u_dist (
    .clk(clk), .rst(rst), .load(dist_valid), .din(dist_value),
    .clr(rd_dist), .full(dist_full), .q(dist_data)
  );

  always_comb begin
    case (req.idx)
      IDX_TX:   rdata_mux = {tx_busy, 23'd0, tx_byte_q};
      IDX_RX:   rdata_mux = {rx_full, 23'd0, rx_data};
      IDX_BTN:  rdata_mux = {28'd0, buttons};
      IDX_SW:   rdata_mux = {28'd0, switches};
      IDX_DIST: rdata_mux = {dist_full, dist_data};
      default:  rdata_mux = rw_q[req.idx];
    endcase
  end

  assign bus_rdata = req.rd ? rdata_mux : '0;

  assign tx_valid      = tx_busy;
  assign tx_byte       = tx_byte_q;
  assign led           = rw_q[IDX_LED][3:0];
  assign rgb0          = rw_q[IDX_RGB0][2:0];
  assign rgb1          = rw_q[IDX_RGB1][2:0];
  assign rgb0_duty     = rw_q[IDX_DUTY0][DUTY_W-1:0];
  assign rgb1_duty     = rw_q[IDX_DUTY1][DUTY_W-1:0];
  assign mot_left_bwd  = rw_q[IDX_LBWD][DUTY_W-1:0];
  assign mot_left_fwd  = rw_q[IDX_LFWD][DUTY_W-1:0];
  assign mot_right_bwd = rw_q[IDX_RBWD][DUTY_W-1:0];
  assign mot_right_fwd = rw_q[IDX_RFWD][DUTY_W-1:0];
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
  parameter int          WIN_BITS  = 12
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_rdata,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_byte,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic        rx_full,
  input logic        dist_valid,
  input logic        dist_full,
  input logic [3:0]  buttons,
  input logic [3:0]  led
);
  localparam int WORD_W = WIN_BITS - 2;
  logic              rd_win;
  logic [WORD_W-1:0] word;

  assign word   = bus_addr[WIN_BITS-1:2];
  assign rd_win = bus_sel && !bus_we && (bus_addr[1:0] == 2'b00) &&
                  (bus_addr[31:WIN_BITS] == BASE_ADDR[31:WIN_BITS]);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!tx_valid && led == 4'd0 && !rx_full && !dist_full));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

  // R8
  tx_done_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready |=> !tx_valid);

  // R9
  rx_bp_chk: assert property (@(posedge clk) disable iff (rst)
    rx_full && !(rd_win && word == WORD_W'(2)) |-> !rx_ready);

  // R10
  rx_take_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_ready |=> rx_full);

  // R11
  dist_set_chk: assert property (@(posedge clk) disable iff (rst)
    dist_valid |=> dist_full);

  // R6
  oob_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_win && word >= WORD_W'(15) |-> bus_rdata == 32'd0);

  // R5
  btn_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_win && word == WORD_W'(8) |-> bus_rdata == {28'd0, buttons});
endmodule

bind periph_regbank regbank_chk #(.BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_full(rx_full),
  .dist_valid(dist_valid), .dist_full(dist_full),
  .buttons(buttons), .led(led)
);

// File: tb/test_periph_regbank.sv
`timescale 1ns/1ps
module test_periph_regbank;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_byte;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_byte = '0;
  logic        dist_valid = 1'b0;
  logic [30:0] dist_value = '0;
  logic [3:0]  buttons = '0, switches = '0;
  logic [3:0]  led;
  logic [2:0]  rgb0, rgb1;
  logic [15:0] rgb0_duty, rgb1_duty, mlb, mlf, mrb, mrf;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       req_q[$];

  always #5 clk = ~clk;

  periph_regbank i_periph_regbank (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_byte(rx_byte), .dist_valid(dist_valid), .dist_value(dist_value),
    .buttons(buttons), .switches(switches), .led(led), .rgb0(rgb0),
    .rgb1(rgb1), .rgb0_duty(rgb0_duty), .rgb1_duty(rgb1_duty),
    .mot_left_bwd(mlb), .mot_left_fwd(mlf), .mot_right_bwd(mrb),
    .mot_right_fwd(mrf)
  );

  function automatic logic [31:0] A(input int idx);
    return BASE + 32'(4 * idx);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data in the middle of every read cycle
  always @(negedge clk) begin
    if (bus_sel && !bus_we) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: actual=%h expected=none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(r, bus_rdata, e);
      end
    end
  end

  // all bus tasks start and end at one time unit after a rising edge
  task automatic wr(input logic [31:0] addr, input logic [31:0] d, input logic [3:0] be);
    bus_sel = 1; bus_we = 1; bus_addr = addr; bus_wdata = d; bus_be = be;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0; bus_be = '0;
  endtask

  task automatic rd(input logic [31:0] addr, input logic [31:0] e, input string req);
    bus_sel = 1; bus_we = 0; bus_addr = addr;
    exp_q.push_back(e); req_q.push_back(req);
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    // R1 reset state
    check("R1 led", {28'd0, led}, 0);
    check("R1 tx_valid", {31'd0, tx_valid}, 0);
    check("R1 rx_ready", {31'd0, rx_ready}, 1);
    check("R1 duty", {16'd0, mrf}, 0);
    for (int i = 0; i < 15; i++) rd(A(i), 32'd0, "R1 readback");

    // R2 byte lanes on debug register
    wr(A(0), 32'hA5A5_1234, 4'hF);
    rd(A(0), 32'hA5A5_1234, "R2 full write");
    wr(A(0), 32'hFFFF_FFFF, 4'b0100);
    rd(A(0), 32'hA5FF_1234, "R2 lane 2 only");

    // R3 LED and colour outputs
    wr(A(3), 32'h0000_000A, 4'hF);
    check("R3 led", {28'd0, led}, 32'hA);
    wr(A(4), 32'h0000_0005, 4'hF);
    check("R3 rgb0 red+blue", {29'd0, rgb0}, 5);
    wr(A(6), 32'h0000_0002, 4'hF);
    check("R3 rgb1 green", {29'd0, rgb1}, 2);

    // R4 duty outputs
    wr(A(5), 32'd20000, 4'hF);
    wr(A(7), 32'd1234, 4'hF);
    wr(A(10), 32'd100, 4'hF);
    wr(A(11), 32'd200, 4'hF);
    wr(A(12), 32'd300, 4'hF);
    wr(A(13), 32'd400, 4'hF);
    check("R4 rgb0_duty", {16'd0, rgb0_duty}, 20000);
    check("R4 rgb1_duty", {16'd0, rgb1_duty}, 1234);
    check("R4 left bwd", {16'd0, mlb}, 100);
    check("R4 left fwd", {16'd0, mlf}, 200);
    check("R4 right bwd", {16'd0, mrb}, 300);
    check("R4 right fwd", {16'd0, mrf}, 400);
    wr(A(13), 32'h0000_FFFF, 4'b0001);
    check("R2 R4 partial lane", {16'd0, mrf}, 32'h1FF);

    // R5 read-only inputs
    buttons = 4'b1011; switches = 4'b0110;
    rd(A(8), 32'hB, "R5 buttons");
    rd(A(9), 32'h6, "R5 switches");
    wr(A(8), 32'hFFFF_FFFF, 4'hF);
    wr(A(9), 32'hFFFF_FFFF, 4'hF);
    wr(A(2), 32'hFFFF_FFFF, 4'hF);
    wr(A(14), 32'hFFFF_FFFF, 4'hF);
    rd(A(8), 32'hB, "R5 buttons after write");
    rd(A(2), 32'h0, "R5 rx after write");
    rd(A(14), 32'h0, "R5 dist after write");

    // R6 unmapped accesses
    rd(A(15), 32'h0, "R6 index 15");
    rd(A(200), 32'h0, "R6 index 200");
    wr(32'h9000_0000, 32'h1111_1111, 4'hF);
    wr(A(0) + 32'd1, 32'h2222_2222, 4'hF);
    rd(32'h9000_0000, 32'h0, "R6 outside window");
    rd(A(0), 32'hA5FF_1234, "R6 debug untouched");

    // R7 transmit start and lanes
    wr(A(1), 32'h8000_0033, 4'b0001);
    check("R7 no start without lane 3", {31'd0, tx_valid}, 0);
    rd(A(1), 32'h0000_0033, "R7 byte only");
    wr(A(1), 32'h8000_0055, 4'hF);
    check("R7 tx_valid", {31'd0, tx_valid}, 1);
    check("R7 tx_byte", {24'd0, tx_byte}, 32'h55);
    rd(A(1), 32'h8000_0055, "R7 busy readback");
    // R8 hold and handshake
    wr(A(1), 32'h8000_0077, 4'hF);
    check("R8 byte frozen", {24'd0, tx_byte}, 32'h55);
    tx_ready = 1;
    idle(1);
    tx_ready = 0;
    check("R8 cleared by handshake", {31'd0, tx_valid}, 0);
    rd(A(1), 32'h0000_0055, "R8 idle readback");

    // R9 receive and back-pressure
    rx_valid = 1; rx_byte = 8'h3C;
    #3 check("R9 ready when empty", {31'd0, rx_ready}, 1);
    @(posedge clk); #1;
    rx_valid = 0;
    check("R9 not ready when full", {31'd0, rx_ready}, 0);
    rd(A(2), 32'h8000_003C, "R9 first read");
    check("R9 ready after read", {31'd0, rx_ready}, 1);
    rd(A(2), 32'h0000_003C, "R9 flag cleared");
    rx_valid = 1; rx_byte = 8'h11; idle(1);
    rx_byte = 8'h99; idle(2);
    check("R9 held off", {31'd0, rx_ready}, 0);
    rx_valid = 0;
    rd(A(2), 32'h8000_0011, "R9 offer while full dropped");
    // R10 byte arrives in the read cycle
    rx_valid = 1; rx_byte = 8'h22; idle(1);
    rx_valid = 0;
    bus_sel = 1; bus_we = 0; bus_addr = A(2);
    rx_valid = 1; rx_byte = 8'h44;
    exp_q.push_back(32'h8000_0022); req_q.push_back("R10 read in event cycle");
    #3 check("R10 ready during read", {31'd0, rx_ready}, 1);
    @(posedge clk); #1;
    bus_sel = 0; rx_valid = 0;
    rd(A(2), 32'h8000_0044, "R10 flag kept");
    rd(A(2), 32'h0000_0044, "R10 flag cleared");

    // R11 distance slot
    dist_valid = 1; dist_value = 31'h0123_4567; idle(1);
    dist_value = 31'h0000_0100; idle(1);
    dist_valid = 0;
    rd(A(14), 32'h8000_0100, "R11 latest value");
    rd(A(14), 32'h0000_0100, "R11 cleared");
    dist_valid = 1; dist_value = 31'h0000_0200; idle(1);
    dist_valid = 0;
    bus_sel = 1; bus_we = 0; bus_addr = A(14);
    dist_valid = 1; dist_value = 31'h7000_0001;
    exp_q.push_back(32'h8000_0200); req_q.push_back("R11 read in event cycle");
    @(posedge clk); #1;
    bus_sel = 0; dist_valid = 0;
    rd(A(14), 32'hF000_0001, "R11 flag kept");
    rd(A(14), 32'h7000_0001, "R11 flag cleared");

    idle(2);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d left expected=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule